// File: doc/BRIEF.md
# Serial Port Bit-Clock and Frame-Sync Generator

This block sits beside a buffered serial port and sets its timing. It picks one of four timing references: the system clock, an external clock pin, the receive clock pin or the transmit clock pin. It divides that reference into a bit clock. The bit clock is delivered as a one-cycle enable pulse in the system clock domain, not as a separate clock net. The block also counts bit clocks to produce a periodic frame-sync of programmable period and width.

When an external pin provides the timing, the block can follow the remote end instead. In that case each rising edge of the receive frame-sync realigns the divider and starts a frame, and the programmed period plays no part. A second output gives the transmit frame-sync. It either copies the frame-sync, or it copies it only for frames that begin while the transmit buffer holds data. All pin inputs pass through two-flop synchronizers before use. A run input acts as a generator-local reset.

Top module: `srg_frame_gen`

## Requirements
- R1: While `rst_n` is low, `bclk_en_o`, `fs_o` and `tx_fs_o` are low. This takes effect at once, without waiting for a clock edge.
- R2: `bclk_en_o` is a one-cycle pulse issued once every `cfg_clk_div`+1 source ticks. With the system clock as source, every system clock cycle is a tick.
- R3: Outside resync mode, successive rising edges of `fs_o` are `cfg_period`+1 bit-clock periods apart. Each frame contains exactly `cfg_period`+1 `bclk_en_o` pulses.
- R4: `fs_o` stays high for `cfg_width`+1 bit-clock periods. If `cfg_width` is at least `cfg_period`, the width is limited to the whole frame, so `fs_o` stays high continuously once it has risen.
- R5: `{cfg_src_mode, cfg_src_sel}` chooses the tick source as follows: 2'b00 external clock pin, 2'b01 receive clock pin, 2'b10 system clock, 2'b11 transmit clock pin (rising edges).
- R6: With `cfg_src_mode`=0, `cfg_edge_fall`=0 makes the selected pin tick on its rising edges, and 1 makes it tick on its falling edges.
- R7: With `cfg_src_mode`=0 and `cfg_resync_en`=1, `fs_o` never rises on its own, whatever `cfg_period` holds. A rising edge on `rx_fs_i` clears the divider and raises `fs_o` three clock edges after the pin changes.
- R8: With `cfg_src_mode`=1, `cfg_resync_en` has no effect, and frames follow `cfg_period`.
- R9: With `cfg_tx_follow`=1, `tx_fs_o` equals `fs_o` on every cycle.
- R10: With `cfg_tx_follow`=0, `tx_fs_o` is high only within a frame-sync pulse whose frame began while `tx_buf_nempty_i` was 1. If the flag was 0 at the frame start, `tx_fs_o` stays low for that whole frame.
- R11: While `gen_run` is 0, the divider and frame counters are held at zero and all outputs go low by the next edge. Once `gen_run` rises, `fs_o` first rises after (`cfg_period`+1)·(`cfg_clk_div`+1)+1 clock edges when the system clock is the source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_run | input | 1 | 1 runs the generator, 0 holds it cleared |
| ext_clk_i | input | 1 | External reference clock pin |
| rx_clk_i | input | 1 | Receive clock pin |
| tx_clk_i | input | 1 | Transmit clock pin |
| rx_fs_i | input | 1 | Receive frame-sync pin |
| tx_buf_nempty_i | input | 1 | Transmit buffer holds data |
| cfg_src_mode | input | 1 | Source mode bit (upper bit of source code) |
| cfg_src_sel | input | 1 | Source select bit (lower bit of source code) |
| cfg_edge_fall | input | 1 | Pin edge polarity in mode 0 |
| cfg_resync_en | input | 1 | Follow receive frame-sync in mode 0 |
| cfg_tx_follow | input | 1 | Transmit frame-sync copies frame-sync |
| cfg_clk_div | input | 8 | Divider value (ticks per bit clock minus one) |
| cfg_period | input | 12 | Frame period minus one, in bit clocks |
| cfg_width | input | 8 | Frame-sync width minus one, in bit clocks |
| bclk_en_o | output | 1 | One-cycle bit-clock enable |
| fs_o | output | 1 | Frame-sync |
| tx_fs_o | output | 1 | Transmit frame-sync |

## Verification
The system-clock source is driven through six divider, period and width combinations that share no factor pattern. The measured frame length, high time and bit-clock count therefore separate an off-by-one in the divider from one in the frame or width counter. These runs also switch between copying and gating of the transmit sync, with the buffer flag at both values. The three pin sources run at clock periods of 12, 8 and 16 system cycles, so the frame length shows which pin was picked. The pin level at the moment `fs_o` rises shows which edge polarity was used. The resync runs hold `rx_fs_i` quiet for longer than a programmed frame and then pulse it. They also set the resync bit in mode 1, which must leave free-running frames unchanged.

// File: rtl/srg_pkg.sv
package srg_pkg;

  // Tick source, encoded as {mode, select}
  typedef enum logic [1:0] {
    SRC_EXT_PIN = 2'b00,
    SRC_RX_PIN  = 2'b01,
    SRC_SYS     = 2'b10,
    SRC_TX_PIN  = 2'b11
  } srg_src_e;

  // Index of each synchronized pin in the pin vector
  localparam int PIN_EXT  = 0;
  localparam int PIN_RX   = 1;
  localparam int PIN_TX   = 2;
  localparam int PIN_RFS  = 3;
  localparam int PIN_CNT  = 4;

endpackage

// File: rtl/srg_rst_sync.sv
module srg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/srg_pin_sync.sv
module srg_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic fall_sel,
  output logic edge_o
);

  localparam int HIST = STAGES + 1;

  logic [HIST-1:0] sh_q;
  logic [HIST-1:0] sh_d;
  logic            now_lvl;
  logic            old_lvl;

  always_comb begin
    sh_d = {sh_q[HIST-2:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign now_lvl = sh_q[STAGES-1];
  assign old_lvl = sh_q[STAGES];

  always_comb begin
    if (fall_sel) begin
      edge_o = old_lvl & ~now_lvl;
    end else begin
      edge_o = now_lvl & ~old_lvl;
    end
  end

endmodule

// File: rtl/srg_bit_div.sv
module srg_bit_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             realign,
  input  logic [DIV_W-1:0] div_val,
  output logic             bclk_en_o
);

  localparam logic [DIV_W-1:0] CNT_ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             pulse_q, pulse_d;

  always_comb begin
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    if (!run) begin
      cnt_d = '0;
    end else if (realign) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_q == div_val) begin
        cnt_d   = '0;
        pulse_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign bclk_en_o = pulse_q;

endmodule

// File: rtl/srg_frame_ctr.sv
module srg_frame_ctr #(
  parameter int PER_W = 12,
  parameter int WID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             bclk_en,
  input  logic             resync_mode,
  input  logic             rfs_rise,
  input  logic [PER_W-1:0] period,
  input  logic [WID_W-1:0] width,
  input  logic             tx_follow,
  input  logic             tx_has_data,
  output logic             fs_o,
  output logic             tx_fs_o
);

  localparam int CMP_W = (PER_W > WID_W) ? PER_W : WID_W;
  localparam logic [PER_W-1:0] POS_ONE = PER_W'(1);
  localparam logic [CMP_W-1:0] WID_ONE = CMP_W'(1);

  logic [PER_W-1:0] pos_q, pos_d;
  logic [CMP_W-1:0] wid_q, wid_d;
  logic             fs_q, fs_d;
  logic             gate_q, gate_d;
  logic [CMP_W-1:0] per_x, wid_x, wid_lim;
  logic             wrap, start;

  // Width limited to the frame length
  always_comb begin
    per_x   = CMP_W'(period);
    wid_x   = CMP_W'(width);
    wid_lim = (wid_x > per_x) ? per_x : wid_x;
  end

  assign wrap  = bclk_en && (pos_q == period);
  assign start = resync_mode ? rfs_rise : wrap;

  always_comb begin
    pos_d  = pos_q;
    wid_d  = wid_q;
    fs_d   = fs_q;
    gate_d = gate_q;
    if (!run) begin
      pos_d  = '0;
      wid_d  = '0;
      fs_d   = 1'b0;
      gate_d = 1'b0;
    end else begin
      if (resync_mode) begin
        pos_d = '0;
      end else if (bclk_en) begin
        pos_d = wrap ? '0 : (pos_q + POS_ONE);
      end
      if (start) begin
        fs_d   = 1'b1;
        wid_d  = '0;
        gate_d = tx_has_data;
      end else if (bclk_en && fs_q) begin
        if (wid_q == wid_lim) begin
          fs_d = 1'b0;
        end else begin
          wid_d = wid_q + WID_ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      wid_q  <= '0;
      fs_q   <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      wid_q  <= wid_d;
      fs_q   <= fs_d;
      gate_q <= gate_d;
    end
  end

  assign fs_o    = fs_q;
  assign tx_fs_o = fs_q & (tx_follow | gate_q);

endmodule

// File: rtl/srg_frame_gen.sv
module srg_frame_gen
  import srg_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int PER_W       = 12,
  parameter int WID_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_run,
  input  logic             ext_clk_i,
  input  logic             rx_clk_i,
  input  logic             tx_clk_i,
  input  logic             rx_fs_i,
  input  logic             tx_buf_nempty_i,
  input  logic             cfg_src_mode,
  input  logic             cfg_src_sel,
  input  logic             cfg_edge_fall,
  input  logic             cfg_resync_en,
  input  logic             cfg_tx_follow,
  input  logic [DIV_W-1:0] cfg_clk_div,
  input  logic [PER_W-1:0] cfg_period,
  input  logic [WID_W-1:0] cfg_width,
  output logic             bclk_en_o,
  output logic             fs_o,
  output logic             tx_fs_o
);

  logic               rst_int_n;
  logic [PIN_CNT-1:0] pin_v;
  logic [PIN_CNT-1:0] pol_v;
  logic [PIN_CNT-1:0] edge_v;
  srg_src_e           src;
  logic               src_tick;
  logic               resync_mode;
  logic               rfs_rise;
  logic               bclk_en;

  srg_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  always_comb begin
    pin_v          = '0;
    pin_v[PIN_EXT] = ext_clk_i;
    pin_v[PIN_RX]  = rx_clk_i;
    pin_v[PIN_TX]  = tx_clk_i;
    pin_v[PIN_RFS] = rx_fs_i;
    pol_v          = '0;
    pol_v[PIN_EXT] = cfg_edge_fall;
    pol_v[PIN_RX]  = cfg_edge_fall;
  end

  generate
    for (genvar gi = 0; gi < PIN_CNT; gi++) begin : g_pin
      srg_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_int_n),
        .pin_i    (pin_v[gi]),
        .fall_sel (pol_v[gi]),
        .edge_o   (edge_v[gi])
      );
    end
  endgenerate

  assign src = srg_src_e'({cfg_src_mode, cfg_src_sel});

  always_comb begin
    case (src)
      SRC_EXT_PIN: src_tick = edge_v[PIN_EXT];
      SRC_RX_PIN:  src_tick = edge_v[PIN_RX];
      SRC_SYS:     src_tick = 1'b1;
      SRC_TX_PIN:  src_tick = edge_v[PIN_TX];
      default:     src_tick = 1'b0;
    endcase
  end

  assign resync_mode = ~cfg_src_mode & cfg_resync_en;
  assign rfs_rise    = edge_v[PIN_RFS];

  srg_bit_div #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .run       (gen_run),
    .tick      (src_tick),
    .realign   (resync_mode & rfs_rise),
    .div_val   (cfg_clk_div),
    .bclk_en_o (bclk_en)
  );

  srg_frame_ctr #(.PER_W(PER_W), .WID_W(WID_W)) u_frame (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .run         (gen_run),
    .bclk_en     (bclk_en),
    .resync_mode (resync_mode),
    .rfs_rise    (rfs_rise),
    .period      (cfg_period),
    .width       (cfg_width),
    .tx_follow   (cfg_tx_follow),
    .tx_has_data (tx_buf_nempty_i),
    .fs_o        (fs_o),
    .tx_fs_o     (tx_fs_o)
  );

  assign bclk_en_o = bclk_en;

endmodule

// File: rtl/srg_frame_gen_chk.sv
module srg_frame_gen_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gen_run,
  input logic             cfg_src_mode,
  input logic             cfg_resync_en,
  input logic             cfg_tx_follow,
  input logic [DIV_W-1:0] cfg_clk_div,
  input logic             rfs_rise,
  input logic             bclk_en_o,
  input logic             fs_o,
  input logic             tx_fs_o
);

  logic rs_mode;
  assign rs_mode = ~cfg_src_mode & cfg_resync_en;

  // R11: stopping the generator clears every output by the next edge
  a_r11_halt_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_run |=> (!fs_o && !bclk_en_o && !tx_fs_o));

  // R9: copy mode ties transmit sync to frame sync
  a_r9_tx_copies_fs: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_tx_follow |-> (tx_fs_o == fs_o));

  // R10: transmit sync never appears outside a frame-sync pulse
  a_r10_tx_inside_fs: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fs_o |-> fs_o);

  // R2: a divide value above zero never yields back-to-back enables
  a_r2_bclk_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_run && bclk_en_o && (cfg_clk_div != '0)) |=> !bclk_en_o);

  // R4: outside resync, frame sync only moves on a bit-clock boundary
  a_r4_fs_on_bclk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_run && $past(gen_run) && !rs_mode && (fs_o != $past(fs_o)))
      |-> $past(bclk_en_o));

  // R7: in resync mode a frame starts only after a receive sync edge
  a_r7_rise_from_rfs: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_run && rs_mode && fs_o && !$past(fs_o)) |-> $past(rfs_rise));

endmodule

bind srg_frame_gen srg_frame_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .gen_run       (gen_run),
  .cfg_src_mode  (cfg_src_mode),
  .cfg_resync_en (cfg_resync_en),
  .cfg_tx_follow (cfg_tx_follow),
  .cfg_clk_div   (cfg_clk_div),
  .rfs_rise      (rfs_rise),
  .bclk_en_o     (bclk_en_o),
  .fs_o          (fs_o),
  .tx_fs_o       (tx_fs_o)
);

// File: tb/srg_frame_gen_bench.sv
`timescale 1ns/1ps
module srg_frame_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gen_run = 1'b0;
  logic        ext_clk = 1'b0, rx_clk = 1'b0, tx_clk = 1'b0;
  logic        rx_fs = 1'b0, tx_nempty = 1'b0;
  logic        c_mode = 1'b1, c_sel = 1'b0, c_fall = 1'b0;
  logic        c_resync = 1'b0, c_follow = 1'b0;
  logic [7:0]  c_div = '0;
  logic [11:0] c_per = '0;
  logic [7:0]  c_wid = '0;
  logic        bclk_en, fs, tx_fs;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  int ph = 0;

  always #2 clk = ~clk;

  // Pin clocks: ext period 12, rx period 8, tx period 16 system cycles
  always @(negedge clk) begin
    ph      <= ph + 1;
    ext_clk <= ((ph % 12) < 6);
    rx_clk  <= ((ph % 8) < 4);
    tx_clk  <= ((ph % 16) < 8);
  end

  srg_frame_gen u_srg_frame_gen (
    .clk (clk), .rst_n (rst_n), .gen_run (gen_run),
    .ext_clk_i (ext_clk), .rx_clk_i (rx_clk), .tx_clk_i (tx_clk),
    .rx_fs_i (rx_fs), .tx_buf_nempty_i (tx_nempty),
    .cfg_src_mode (c_mode), .cfg_src_sel (c_sel), .cfg_edge_fall (c_fall),
    .cfg_resync_en (c_resync), .cfg_tx_follow (c_follow),
    .cfg_clk_div (c_div), .cfg_period (c_per), .cfg_width (c_wid),
    .bclk_en_o (bclk_en), .fs_o (fs), .tx_fs_o (tx_fs)
  );

  // div, per, wid, follow, nempty, exp period, exp high, exp tx high
  localparam int NV = 6;
  localparam int VEC [NV][8] = '{
    '{0, 3, 0, 1, 0,  4, 1, 1},
    '{1, 4, 1, 0, 1, 10, 4, 4},
    '{2, 5, 2, 0, 0, 18, 9, 0},
    '{3, 2, 0, 1, 0, 12, 4, 4},
    '{0, 7, 3, 0, 1,  8, 4, 4},
    '{4, 1, 0, 1, 1, 10, 5, 5}
  };

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic restart(input bit mode, input bit sel, input bit fall,
                         input bit rsy, input bit fol, input int div,
                         input int per, input int wid, input bit nemp);
    @(negedge clk);
    gen_run = 1'b0;
    @(negedge clk);
    c_mode = mode; c_sel = sel; c_fall = fall; c_resync = rsy;
    c_follow = fol; c_div = 8'(div); c_per = 12'(per); c_wid = 8'(wid);
    tx_nempty = nemp;
    @(negedge clk);
    gen_run = 1'b1;
  endtask

  task automatic wait_rise(output bit ok, output bit pin_at);
    bit prev = fs;
    ok = 0; pin_at = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (fs && !prev) begin ok = 1; pin_at = ext_clk; break; end
      prev = fs;
    end
  endtask

  task automatic measure(output int per, output int hi, output int txh,
                         output int nb, output bit pin_at);
    bit ok;
    bit prev;
    wait_rise(ok, pin_at);
    wait_rise(ok, pin_at);
    per = 1; hi = 1; txh = tx_fs ? 1 : 0; nb = bclk_en ? 1 : 0;
    prev = fs;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (fs && !prev) break;
      per++; hi += fs ? 1 : 0; txh += tx_fs ? 1 : 0; nb += bclk_en ? 1 : 0;
      prev = fs;
    end
    if (!ok) per = -1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int p, h, t, n, cnt;
    bit pin, ok;
    // R1: reset state
    repeat (5) @(negedge clk);
    check("R1 bclk_en in reset", int'(bclk_en), 0);
    check("R1 fs in reset", int'(fs), 0);
    check("R1 tx_fs in reset", int'(tx_fs), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R3 R4 R9 R10: system-clock source vectors
    for (int v = 0; v < NV; v++) begin
      restart(1'b1, 1'b0, 1'b0, 1'b0, VEC[v][3] != 0, VEC[v][0],
              VEC[v][1], VEC[v][2], VEC[v][4] != 0);
      measure(p, h, t, n, pin);
      check("R3 frame length", p, VEC[v][5]);
      check("R4 fs high time", h, VEC[v][6]);
      check("R9/R10 tx_fs high time", t, VEC[v][7]);
      check("R2 bclk pulses per frame", n, VEC[v][1] + 1);
    end

    // R11: first frame one full period after run
    restart(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1, 2, 0, 1'b0);
    repeat (6) @(negedge clk);
    check("R11 no fs before first period", int'(fs), 0);
    @(negedge clk);
    check("R11 first fs after period", int'(fs), 1);

    // R11: stop holds outputs low
    restart(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 0, 1, 0, 1'b0);
    repeat (20) @(negedge clk);
    gen_run = 1'b0;
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      cnt += (bclk_en | fs | tx_fs) ? 1 : 0;
    end
    check("R11 outputs low while stopped", cnt, 0);

    // R4: width clamp, fs stays high
    restart(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0, 3, 9, 1'b0);
    wait_rise(ok, pin);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      cnt += fs ? 1 : 0;
    end
    check("R4 clamped width keeps fs high", cnt, 20);

    // R5 R6: pin sources
    restart(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 0, 3, 0, 1'b0);
    measure(p, h, t, n, pin);
    check("R5 ext pin frame length", p, 48);
    check("R6 rising edge pin level at fs rise", int'(pin), 1);
    restart(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 0, 3, 0, 1'b0);
    measure(p, h, t, n, pin);
    check("R5 ext pin falling frame length", p, 48);
    check("R6 falling edge pin level at fs rise", int'(pin), 0);
    restart(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 0, 3, 0, 1'b0);
    measure(p, h, t, n, pin);
    check("R5 rx clock pin frame length", p, 32);
    restart(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 0, 3, 0, 1'b0);
    measure(p, h, t, n, pin);
    check("R5 tx clock pin frame length", p, 64);

    // R8: resync bit ignored in mode 1
    restart(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1, 2, 0, 1'b0);
    measure(p, h, t, n, pin);
    check("R8 mode1 resync ignored frame length", p, 6);

    // R7: resync to receive frame-sync
    restart(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 0, 3, 0, 1'b0);
    cnt = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      cnt += fs ? 1 : 0;
    end
    check("R7 no fs without rx sync", cnt, 0);
    rx_fs = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 fs low two edges after rx sync", int'(fs), 0);
    @(negedge clk);
    check("R7 fs high three edges after rx sync", int'(fs), 1);
    repeat (30) @(negedge clk);
    rx_fs = 1'b0;
    cnt = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      cnt += fs ? 1 : 0;
    end
    check("R7 no repeat fs without new edge", cnt, 0);

    // R1: asynchronous reset while running
    restart(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 0, 0, 0, 1'b0);
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    check("R1 async reset clears outputs", int'(bclk_en | fs | tx_fs), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule